// File: doc/BRIEF.md
# Two-Hop Look-Ahead Wakeup Generator

This block sits beside the routing stage of a router in a two-dimensional mesh with dimension-ordered (X first, then Y) look-ahead routing. Whenever a head flit is presented with its destination coordinates, the block walks the route forward and works out two things. The first is the link the flit leaves on. The second is which power-gated input-port domain of the router two hops downstream the flit will occupy. It then raises a one-cycle wakeup request. The request is tagged with the target port and the flit's virtual channel, and it travels on the sideband of that outgoing link. Because the request goes out when the flit is still two routers short of the target domain, the wakeup latency of that domain is hidden behind the flit's own transit time.

The first downstream router is never woken by this block. Its input buffer is either kept permanently powered or takes the wakeup penalty. When the destination lies one or two hops away, there is no second-hop input port to prepare. The request then names the ejection port toward the core of the destination router instead. A head flit already at its destination produces no request at all.

Top module: `lah_wakeup_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, wk_vld is 0 and wk_link and wk_port are all zeros.
- R2: A head flit with destination different from the local node gives exactly one wk_vld pulse, in the cycle after head_vld was high. A cycle with head_vld low gives no pulse in the following cycle. Back-to-back heads give back-to-back pulses.
- R3: A head flit whose destination equals the local coordinates produces no wakeup.
- R4: wk_link is the one-hot first move under X-then-Y routing. The bit encoding is bit0 core, bit1 X+, bit2 X-, bit3 Y+, bit4 Y-. X+ means x grows and Y+ means y grows. The core bit is never set in wk_link.
- R5: When the Manhattan distance is 3 or more, wk_far is 1 and wk_port is the one-hot input port through which the flit enters the router two hops away. That port is the opposite of the second XY move: X+ gives X-, X- gives X+, Y+ gives Y-, Y- gives Y+.
- R6: When the distance is 1 or 2, wk_far is 0 and wk_port is the core bit (5'b00001).
- R7: wk_vc equals the head_vc that accompanied the head flit.
- R8: Whenever wk_vld is 0, wk_link and wk_port are zero. Whenever wk_vld is 1, each of them has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_vld | input | 1 | A head flit is presented this cycle |
| head_vc | input | VCW | Virtual channel of the head flit |
| dst_x | input | CW | Destination column |
| dst_y | input | CW | Destination row |
| loc_x | input | CW | Column of this router |
| loc_y | input | CW | Row of this router |
| wk_vld | output | 1 | One-cycle wakeup request |
| wk_link | output | 5 | One-hot outgoing link carrying the request |
| wk_port | output | 5 | One-hot input port domain to wake |
| wk_vc | output | VCW | Virtual channel to wake |
| wk_far | output | 1 | 1: second-hop input port; 0: destination core port |

## Verification
The bench builds the block with a 4x4 mesh and four virtual channels. That is small enough that random coordinates often land on the short cases: same node, one hop, two hops, and pure-X or pure-Y routes. The mesh edges and corners are also hit often, where only some directions exist. Directed corner-to-corner, edge and turn routes cover the longest paths, the single-dimension paths and the X-to-Y turn at the second hop. Random stimulus with idle gaps and back-to-back heads exercises the one-pulse-per-head rule.

// File: rtl/lah_pkg.sv
package lah_pkg;
  localparam int NPORT = 5;
  localparam int P_CORE = 0;
  localparam int P_XP   = 1;
  localparam int P_XM   = 2;
  localparam int P_YP   = 3;
  localparam int P_YM   = 4;

  typedef logic [NPORT-1:0] port_oh_t;

  // Input port at the receiving router for a given direction of travel.
  function automatic port_oh_t entry_port(input port_oh_t mv);
    port_oh_t r;
    r = '0;
    if (mv[P_XP]) r[P_XM] = 1'b1;
    if (mv[P_XM]) r[P_XP] = 1'b1;
    if (mv[P_YP]) r[P_YM] = 1'b1;
    if (mv[P_YM]) r[P_YP] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/lah_xy_step.sv
module lah_xy_step
  import lah_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output port_oh_t      mv,
  output logic [CW-1:0] nxt_x,
  output logic [CW-1:0] nxt_y
);
  always_comb begin
    mv    = '0;
    nxt_x = cur_x;
    nxt_y = cur_y;
    if (dst_x > cur_x) begin
      mv[P_XP] = 1'b1;
      nxt_x    = cur_x + 1'b1;
    end else if (dst_x < cur_x) begin
      mv[P_XM] = 1'b1;
      nxt_x    = cur_x - 1'b1;
    end else if (dst_y > cur_y) begin
      mv[P_YP] = 1'b1;
      nxt_y    = cur_y + 1'b1;
    end else if (dst_y < cur_y) begin
      mv[P_YM] = 1'b1;
      nxt_y    = cur_y - 1'b1;
    end else begin
      mv[P_CORE] = 1'b1;
    end
  end
endmodule

// File: rtl/lah_route_chain.sv
module lah_route_chain
  import lah_pkg::*;
#(
  parameter int CW     = 2,
  parameter int STAGES = 3
) (
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output port_oh_t      mv [STAGES]
);
  logic [CW-1:0] px [STAGES+1];
  logic [CW-1:0] py [STAGES+1];

  assign px[0] = src_x;
  assign py[0] = src_y;

  for (genvar s = 0; s < STAGES; s++) begin : g_hop
    lah_xy_step #(.CW(CW)) step_i (
      .cur_x (px[s]),
      .cur_y (py[s]),
      .dst_x (dst_x),
      .dst_y (dst_y),
      .mv    (mv[s]),
      .nxt_x (px[s+1]),
      .nxt_y (py[s+1])
    );
  end
endmodule

// File: rtl/lah_wake_sel.sv
module lah_wake_sel
  import lah_pkg::*;
(
  input  port_oh_t mv0,
  input  port_oh_t mv1,
  input  port_oh_t mv2,
  output logic     req,
  output port_oh_t link,
  output port_oh_t port,
  output logic     far
);
  always_comb begin
    req  = 1'b0;
    link = '0;
    port = '0;
    far  = 1'b0;
    if (!mv0[P_CORE]) begin
      req  = 1'b1;
      link = mv0;
      if (mv1[P_CORE] || mv2[P_CORE]) begin
        port[P_CORE] = 1'b1;
      end else begin
        port = entry_port(mv1);
        far  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lah_wakeup_gen.sv
module lah_wakeup_gen
  import lah_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int NUM_VC = 4,
  localparam int MAXD  = (MESH_X > MESH_Y) ? MESH_X : MESH_Y,
  localparam int CW    = (MAXD > 2) ? $clog2(MAXD) : 1,
  localparam int VCW   = (NUM_VC > 2) ? $clog2(NUM_VC) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           head_vld,
  input  logic [VCW-1:0] head_vc,
  input  logic [CW-1:0]  dst_x,
  input  logic [CW-1:0]  dst_y,
  input  logic [CW-1:0]  loc_x,
  input  logic [CW-1:0]  loc_y,
  output logic           wk_vld,
  output logic [4:0]     wk_link,
  output logic [4:0]     wk_port,
  output logic [VCW-1:0] wk_vc,
  output logic           wk_far
);
  localparam int STAGES = 3;

  port_oh_t mv [STAGES];
  logic     s_req, s_far;
  port_oh_t s_link, s_port;

  lah_route_chain #(.CW(CW), .STAGES(STAGES)) chain_i (
    .src_x (loc_x),
    .src_y (loc_y),
    .dst_x (dst_x),
    .dst_y (dst_y),
    .mv    (mv)
  );

  lah_wake_sel sel_i (
    .mv0  (mv[0]),
    .mv1  (mv[1]),
    .mv2  (mv[2]),
    .req  (s_req),
    .link (s_link),
    .port (s_port),
    .far  (s_far)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wk_vld  <= 1'b0;
      wk_link <= '0;
      wk_port <= '0;
      wk_vc   <= '0;
      wk_far  <= 1'b0;
    end else begin
      wk_vld  <= head_vld && s_req;
      wk_link <= (head_vld && s_req) ? s_link : '0;
      wk_port <= (head_vld && s_req) ? s_port : '0;
      wk_vc   <= head_vc;
      wk_far  <= head_vld && s_far;
    end
  end
endmodule

// File: rtl/lah_wakeup_chk.sv
module lah_wakeup_chk #(
  parameter int CW  = 2,
  parameter int VCW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           head_vld,
  input logic [VCW-1:0] head_vc,
  input logic [CW-1:0]  dst_x,
  input logic [CW-1:0]  dst_y,
  input logic [CW-1:0]  loc_x,
  input logic [CW-1:0]  loc_y,
  input logic           wk_vld,
  input logic [4:0]     wk_link,
  input logic [4:0]     wk_port,
  input logic [VCW-1:0] wk_vc,
  input logic           wk_far
);
  assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (head_vld && (dst_x != loc_x || dst_y != loc_y)) |=> wk_vld);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !head_vld |=> !wk_vld);
  assert_self_R3: assert property (@(posedge clk) disable iff (rst)
    (head_vld && dst_x == loc_x && dst_y == loc_y) |=> !wk_vld);
  assert_link_not_core_R4: assert property (@(posedge clk) disable iff (rst)
    wk_vld |-> !wk_link[0]);
  assert_far_port_R5: assert property (@(posedge clk) disable iff (rst)
    (wk_vld && wk_far) |-> !wk_port[0]);
  assert_near_port_R6: assert property (@(posedge clk) disable iff (rst)
    (wk_vld && !wk_far) |-> wk_port == 5'b00001);
  assert_vc_R7: assert property (@(posedge clk) disable iff (rst)
    head_vld |=> wk_vc == $past(head_vc));
  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !wk_vld |-> (wk_link == 5'b0 && wk_port == 5'b0));
  assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    wk_vld |-> ($countones(wk_link) == 1 && $countones(wk_port) == 1));
endmodule

bind lah_wakeup_gen lah_wakeup_chk #(.CW(CW), .VCW(VCW)) chk_i (
  .clk(clk), .rst(rst), .head_vld(head_vld), .head_vc(head_vc),
  .dst_x(dst_x), .dst_y(dst_y), .loc_x(loc_x), .loc_y(loc_y),
  .wk_vld(wk_vld), .wk_link(wk_link), .wk_port(wk_port),
  .wk_vc(wk_vc), .wk_far(wk_far)
);

// File: tb/lah_wakeup_gen_tb_top.sv
module lah_wakeup_gen_tb_top;
  localparam int MX  = 4;
  localparam int MY  = 4;
  localparam int NVC = 4;
  localparam int CW  = 2;
  localparam int VCW = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           head_vld = 1'b0;
  logic [VCW-1:0] head_vc = '0;
  logic [CW-1:0]  dst_x = '0, dst_y = '0, loc_x = '0, loc_y = '0;
  logic           wk_vld, wk_far;
  logic [4:0]     wk_link, wk_port;
  logic [VCW-1:0] wk_vc;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic           e_vld, e_far;
  logic [4:0]     e_link, e_port;
  logic [VCW-1:0] e_vc;

  always #5 clk = ~clk;

  lah_wakeup_gen #(.MESH_X(MX), .MESH_Y(MY), .NUM_VC(NVC)) dut_i (
    .clk(clk), .rst(rst), .head_vld(head_vld), .head_vc(head_vc),
    .dst_x(dst_x), .dst_y(dst_y), .loc_x(loc_x), .loc_y(loc_y),
    .wk_vld(wk_vld), .wk_link(wk_link), .wk_port(wk_port),
    .wk_vc(wk_vc), .wk_far(wk_far)
  );

  function automatic logic [4:0] dir_of(input int dx, input int dy);
    if (dx > 0) return 5'b00010;
    if (dx < 0) return 5'b00100;
    if (dy > 0) return 5'b01000;
    if (dy < 0) return 5'b10000;
    return 5'b00001;
  endfunction

  function automatic logic [4:0] flip(input logic [4:0] d);
    case (d)
      5'b00010: return 5'b00100;
      5'b00100: return 5'b00010;
      5'b01000: return 5'b10000;
      5'b10000: return 5'b01000;
      default:  return 5'b00000;
    endcase
  endfunction

  task automatic predict(input int lx, input int ly, input int dxx, input int dyy,
                         input bit v, input int vc);
    int dx, dy, hops, rx, ry;
    dx = dxx - lx;
    dy = dyy - ly;
    hops = (dx < 0 ? -dx : dx) + (dy < 0 ? -dy : dy);
    e_vc = vc[VCW-1:0];
    e_vld = v && hops != 0;
    e_link = e_vld ? dir_of(dx, dy) : 5'b0;
    e_far = e_vld && hops >= 3;
    rx = dx; ry = dy;
    if (dx > 0) rx = dx - 1;
    else if (dx < 0) rx = dx + 1;
    else if (dy > 0) ry = dy - 1;
    else if (dy < 0) ry = dy + 1;
    if (!e_vld) e_port = 5'b0;
    else if (!e_far) e_port = 5'b00001;
    else e_port = flip(dir_of(rx, ry));
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic verify();
    if (e_vld) begin
      chk("R2 wk_vld pulse", 32'(wk_vld), 32'(e_vld));
      chk("R4 wk_link", 32'(wk_link), 32'(e_link));
      chk(e_far ? "R5 wk_port far" : "R6 wk_port near", 32'(wk_port), 32'(e_port));
      chk(e_far ? "R5 wk_far" : "R6 wk_far", 32'(wk_far), 32'(e_far));
      chk("R7 wk_vc", 32'(wk_vc), 32'(e_vc));
    end else begin
      chk("R2/R3 no pulse", 32'(wk_vld), 32'd0);
      chk("R8 quiet link", 32'(wk_link), 32'd0);
      chk("R8 quiet port", 32'(wk_port), 32'd0);
    end
  endtask

  // Drive at a falling edge; the result is registered at the next rising
  // edge and checked at the falling edge after it.
  task automatic step(input bit v, input int lx, input int ly,
                      input int dxx, input int dyy, input int vc);
    head_vld = v;
    loc_x = lx[CW-1:0]; loc_y = ly[CW-1:0];
    dst_x = dxx[CW-1:0]; dst_y = dyy[CW-1:0];
    head_vc = vc[VCW-1:0];
    predict(lx, ly, dxx, dyy, v, vc);
    @(negedge clk);
    verify();
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1 reset wk_vld", 32'(wk_vld), 32'd0);
    chk("R1 reset wk_port", 32'(wk_port), 32'd0);
    head_vld = 1'b1; dst_x = 2'd3; dst_y = 2'd3;
    @(negedge clk);
    rst = 1'b0;
    head_vld = 1'b0;
    chk("R1 reset wk_link", 32'(wk_link), 32'd0);
    @(negedge clk);
    chk("R1 first cycle after reset", 32'(wk_vld), 32'd0);

    // Directed corners
    step(1, 0, 0, 3, 3, 1);   // R5 long route, turn at hop two? no: X then X
    step(1, 0, 0, 1, 3, 2);   // R5 X then Y turn at second hop
    step(1, 3, 3, 0, 0, 3);   // R5 toward minus corner
    step(1, 2, 0, 2, 3, 0);   // R5 pure Y
    step(1, 1, 1, 1, 1, 2);   // R3 same node
    step(1, 1, 1, 2, 1, 1);   // R6 one hop
    step(1, 1, 1, 2, 2, 3);   // R6 two hops with turn
    step(1, 3, 2, 3, 0, 0);   // R6 two hops Y-
    step(1, 3, 0, 0, 0, 1);   // R5 pure X-
    step(0, 0, 0, 3, 3, 0);   // R2 no head
    step(1, 0, 3, 3, 0, 2);   // R5 corner to corner

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 7,
           $urandom_range(MX-1, 0), $urandom_range(MY-1, 0),
           $urandom_range(MX-1, 0), $urandom_range(MY-1, 0),
           $urandom_range(NVC-1, 0));
    end
    step(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule